// File: doc/BRIEF.md
# Self-Programming Command Arming Controller

This block sits between a CPU and a flash array and gates the CPU's self-programming store instruction. The CPU writes a 5-bit command word into the block's command register. The write arms the command for a short window of clock cycles. A store strobe from the instruction decoder inside that window then fires the armed operation. The operations are: fill one word of the temporary page buffer, erase a page, write a page, re-enable reads of the read-while-write section, or set lock bits. With the lock-bit command armed, a load strobe inside a shorter window returns lock or fuse bits in place of memory data.

The block splits a 24-bit pointer into a word index within a page and a page number. For page erase and page write it issues a start pulse to the flash array and then waits for the array's busy signal to fall. It halts the CPU while an erase or write targets the upper, no-read-while-write region. The enable bit stays set until the long operation ends, so software can poll it. Page size, the section boundary and both window lengths are parameters.

Top module: `spm_arm_ctrl`

## Requirements
- R1: After reset the command register reads 00000, and buf_we, op_start, lock_wr, rww_en, sig_rd and cpu_halt are all low.
- R2: A register write is accepted only when the written value is 00001 (fill), 00011 (erase), 00101 (page write), 01001 (lock) or 10001 (section re-enable). Bit 0 is the enable, bit 1 is erase, bit 2 is page write, bit 3 is lock and bit 4 is re-enable. Any other value leaves the register unchanged, whether it was idle or armed. An accepted value reads back on cmd_rdata in the next cycle.
- R3: An accepted write arms the command for ARM_CYCLES (4) cycles. A store strobe in any of those cycles executes the command, including the fourth. With no strobe, the register returns to 00000 after the fourth cycle, and a later strobe has no effect.
- R4: Fill with a store strobe pulses buf_we for one cycle, starting one cycle after the strobe. buf_word carries pointer bits [WORD_BITS:1], so pointer bit 0 is ignored. buf_wdata carries data_in. The register then reads 00000.
- R5: Erase or page write with a store strobe pulses op_start for one cycle, starting one cycle after the strobe. op_page carries pointer bits [ADDR_BITS-1:WORD_BITS+1]. op_is_write is 1 for page write and 0 for erase. buf_we stays low, so data_in is ignored.
- R6: During an erase or page write, the register keeps its code with bit 0 set, and register writes are ignored. The register clears in the cycle after op_busy falls.
- R7: cpu_halt is high from the op_start cycle until the register clears, if op_page >= NRWW_FIRST_PAGE. Otherwise it stays low.
- R8: With 01001 armed, a load strobe in the first LOAD_CYCLES (3) armed cycles pulses sig_rd one cycle later. The returned data is fuse_val when pointer bit 0 is 1 and lock_val when it is 0. A load strobe in the fourth armed cycle has no effect.
- R9: A store strobe with 01001 armed pulses lock_wr one cycle later, with lock_wdata equal to data_in[7:0]. A store strobe with 10001 armed pulses rww_en one cycle later. In both cases the register then clears.
- R10: A legal write while a command is armed replaces the command and restarts the full window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 5 | Command value being written |
| cmd_rdata | output | 5 | Current command register value |
| ptr | input | PTR_W (24) | Flash byte pointer |
| data_in | input | DATA_W (16) | Data word pair from the CPU |
| st_strobe | input | 1 | Store-to-program-memory instruction strobe |
| ld_strobe | input | 1 | Load-from-program-memory instruction strobe |
| lock_val | input | FUSE_W (8) | Current lock bits |
| fuse_val | input | FUSE_W (8) | Current fuse bits |
| buf_we | output | 1 | Page buffer write enable |
| buf_word | output | WORD_BITS (7) | Page buffer word index |
| buf_wdata | output | DATA_W (16) | Page buffer write data |
| lock_wr | output | 1 | Lock bit write pulse |
| lock_wdata | output | FUSE_W (8) | Lock bit write value |
| rww_en | output | 1 | Read-while-write section re-enable pulse |
| sig_rd | output | 1 | Lock/fuse read result valid |
| sig_rdata | output | FUSE_W (8) | Lock/fuse read result |
| op_start | output | 1 | Flash long-operation start pulse |
| op_is_write | output | 1 | 1 for page write, 0 for page erase |
| op_page | output | PAGE_BITS (9) | Page number of the long operation |
| op_busy | input | 1 | Flash array busy |
| cpu_halt | output | 1 | CPU halt request |

## Verification
Every action output is registered, so each result appears exactly one clock after the edge that samples its strobe. A register write shows on cmd_rdata one clock after its edge. Expiry is seen in the first cycle after the fourth armed cycle, and the register clears one clock after op_busy falls. The bench drives inputs and samples outputs 1 ns after the falling edge, so each rising edge between drive and sample is counted by hand. The window edges are hit exactly: a strobe in the fourth armed cycle, a strobe one cycle later, a load in the third armed cycle and a load in the fourth.

// File: rtl/spm_pkg.sv
package spm_pkg;

   localparam int CMD_W = 5;

   localparam logic [CMD_W-1:0] PAT_FILL  = 5'b00001;
   localparam logic [CMD_W-1:0] PAT_ERASE = 5'b00011;
   localparam logic [CMD_W-1:0] PAT_WRITE = 5'b00101;
   localparam logic [CMD_W-1:0] PAT_LOCK  = 5'b01001;
   localparam logic [CMD_W-1:0] PAT_RWW   = 5'b10001;

   typedef enum logic [2:0] {
      K_NONE,
      K_FILL,
      K_ERASE,
      K_WRITE,
      K_LOCK,
      K_RWW
   } spm_kind_e;

   function automatic spm_kind_e kind_of(input logic [CMD_W-1:0] code);
      spm_kind_e k;
      case (code)
         PAT_FILL:  k = K_FILL;
         PAT_ERASE: k = K_ERASE;
         PAT_WRITE: k = K_WRITE;
         PAT_LOCK:  k = K_LOCK;
         PAT_RWW:   k = K_RWW;
         default:   k = K_NONE;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/spm_cmd_decode.sv
module spm_cmd_decode
   import spm_pkg::*;
(
   input  logic [CMD_W-1:0] code,
   output logic             legal,
   output spm_kind_e        kind
);

   always_comb begin
      kind  = kind_of(code);
      legal = (kind != K_NONE);
   end

endmodule

// File: rtl/spm_arm_timer.sv
module spm_arm_timer #(
   parameter  int ARM_CYCLES  = 4,
   parameter  int LOAD_CYCLES = 3,
   localparam int CW          = $clog2(ARM_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic consume,
   output logic armed,
   output logic expire,
   output logic load_ok
);

   localparam logic [CW-1:0] FULL   = CW'(ARM_CYCLES);
   localparam logic [CW-1:0] LD_MIN = CW'(ARM_CYCLES - LOAD_CYCLES + 1);
   localparam logic [CW-1:0] LAST   = CW'(1);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (arm) begin
         left_q <= FULL;
      end else if (consume) begin
         left_q <= '0;
      end else if (left_q != '0) begin
         left_q <= left_q - LAST;
      end
   end

   always_comb begin
      armed   = (left_q != '0);
      expire  = armed && !arm && !consume && (left_q == LAST);
      load_ok = armed && (left_q >= LD_MIN);
   end

endmodule

// File: rtl/spm_addr_split.sv
module spm_addr_split #(
   parameter  int PTR_W           = 24,
   parameter  int ADDR_BITS       = 17,
   parameter  int PAGE_WORDS      = 128,
   parameter  int NRWW_FIRST_PAGE = 480,
   localparam int WORD_BITS       = $clog2(PAGE_WORDS),
   localparam int PAGE_BITS       = ADDR_BITS - 1 - WORD_BITS
) (
   input  logic [PTR_W-1:0]     ptr,
   output logic [WORD_BITS-1:0] word_idx,
   output logic [PAGE_BITS-1:0] page_idx,
   output logic                 sel_bit,
   output logic                 in_nrww
);

   localparam int NUM_PAGES = 1 << PAGE_BITS;

   logic unused_ptr_hi;

   assign word_idx      = ptr[WORD_BITS:1];
   assign page_idx      = ptr[ADDR_BITS-1:WORD_BITS+1];
   assign sel_bit       = ptr[0];
   assign unused_ptr_hi = ^ptr[PTR_W-1:ADDR_BITS-1];

   generate
      if (NRWW_FIRST_PAGE <= 0) begin : g_all_nrww
         assign in_nrww = 1'b1;
      end else if (NRWW_FIRST_PAGE >= NUM_PAGES) begin : g_no_nrww
         assign in_nrww = 1'b0;
      end else begin : g_cmp_nrww
         localparam logic [PAGE_BITS-1:0] BOUND = PAGE_BITS'(NRWW_FIRST_PAGE);
         assign in_nrww = (page_idx >= BOUND);
      end
   endgenerate

endmodule

// File: rtl/spm_op_seq.sv
module spm_op_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic halt_req,
   input  logic op_busy,
   output logic op_start,
   output logic active,
   output logic done,
   output logic cpu_halt
);

   logic active_q;
   logic seen_q;
   logic start_q;
   logic halt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         seen_q   <= 1'b0;
         start_q  <= 1'b0;
         halt_q   <= 1'b0;
      end else begin
         start_q <= start;
         if (start) begin
            active_q <= 1'b1;
            seen_q   <= 1'b0;
            halt_q   <= halt_req;
         end else if (done) begin
            active_q <= 1'b0;
            seen_q   <= 1'b0;
            halt_q   <= 1'b0;
         end else if (active_q && op_busy) begin
            seen_q <= 1'b1;
         end
      end
   end

   always_comb begin
      done     = active_q && seen_q && !op_busy;
      active   = active_q;
      op_start = start_q;
      cpu_halt = halt_q;
   end

endmodule

// File: rtl/spm_arm_ctrl.sv
module spm_arm_ctrl
   import spm_pkg::*;
#(
   parameter  int PTR_W           = 24,
   parameter  int ADDR_BITS       = 17,
   parameter  int PAGE_WORDS      = 128,
   parameter  int NRWW_FIRST_PAGE = 480,
   parameter  int ARM_CYCLES      = 4,
   parameter  int LOAD_CYCLES     = 3,
   parameter  int DATA_W          = 16,
   parameter  int FUSE_W          = 8,
   localparam int WORD_BITS       = $clog2(PAGE_WORDS),
   localparam int PAGE_BITS       = ADDR_BITS - 1 - WORD_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_wr,
   input  logic [4:0]           cmd_wdata,
   output logic [4:0]           cmd_rdata,
   input  logic [PTR_W-1:0]     ptr,
   input  logic [DATA_W-1:0]    data_in,
   input  logic                 st_strobe,
   input  logic                 ld_strobe,
   input  logic [FUSE_W-1:0]    lock_val,
   input  logic [FUSE_W-1:0]    fuse_val,
   output logic                 buf_we,
   output logic [WORD_BITS-1:0] buf_word,
   output logic [DATA_W-1:0]    buf_wdata,
   output logic                 lock_wr,
   output logic [FUSE_W-1:0]    lock_wdata,
   output logic                 rww_en,
   output logic                 sig_rd,
   output logic [FUSE_W-1:0]    sig_rdata,
   output logic                 op_start,
   output logic                 op_is_write,
   output logic [PAGE_BITS-1:0] op_page,
   input  logic                 op_busy,
   output logic                 cpu_halt
);

   initial begin
      if (PAGE_WORDS != (1 << WORD_BITS))
         $error("PAGE_WORDS must be a power of two");
      if (PAGE_BITS < 1)
         $error("ADDR_BITS too small for PAGE_WORDS");
      if (ADDR_BITS > PTR_W)
         $error("ADDR_BITS exceeds PTR_W");
      if (LOAD_CYCLES < 1 || LOAD_CYCLES > ARM_CYCLES)
         $error("LOAD_CYCLES must lie in 1..ARM_CYCLES");
      if (DATA_W < FUSE_W)
         $error("DATA_W must cover FUSE_W");
   end

   // decode of the value being written
   logic      wr_legal;
   spm_kind_e wr_kind;

   spm_cmd_decode u_dec (
      .code  (cmd_wdata),
      .legal (wr_legal),
      .kind  (wr_kind)
   );

   logic      unused_wr_kind;
   assign unused_wr_kind = ^wr_kind;

   // pointer fields
   logic [WORD_BITS-1:0] word_idx;
   logic [PAGE_BITS-1:0] page_idx;
   logic                 sel_bit;
   logic                 in_nrww;

   spm_addr_split #(
      .PTR_W           (PTR_W),
      .ADDR_BITS       (ADDR_BITS),
      .PAGE_WORDS      (PAGE_WORDS),
      .NRWW_FIRST_PAGE (NRWW_FIRST_PAGE)
   ) u_split (
      .ptr      (ptr),
      .word_idx (word_idx),
      .page_idx (page_idx),
      .sel_bit  (sel_bit),
      .in_nrww  (in_nrww)
   );

   // arming window
   logic [4:0] cmd_q;
   spm_kind_e  cur_kind;
   logic       armed;
   logic       expire;
   logic       load_ok;
   logic       op_active;
   logic       op_done;
   logic       arm;
   logic       fire;
   logic       long_op;
   logic       load_fire;

   always_comb begin
      cur_kind  = kind_of(cmd_q);
      arm       = cmd_wr && wr_legal && !op_active;
      fire      = armed && st_strobe && !arm;
      long_op   = fire && ((cur_kind == K_ERASE) || (cur_kind == K_WRITE));
      load_fire = load_ok && ld_strobe && !arm && (cur_kind == K_LOCK);
   end

   spm_arm_timer #(
      .ARM_CYCLES  (ARM_CYCLES),
      .LOAD_CYCLES (LOAD_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (arm),
      .consume (fire),
      .armed   (armed),
      .expire  (expire),
      .load_ok (load_ok)
   );

   // long-operation sequencer
   spm_op_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (long_op),
      .halt_req (in_nrww),
      .op_busy  (op_busy),
      .op_start (op_start),
      .active   (op_active),
      .done     (op_done),
      .cpu_halt (cpu_halt)
   );

   // command register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (arm) begin
         cmd_q <= cmd_wdata;
      end else if ((fire && !long_op) || expire || op_done) begin
         cmd_q <= '0;
      end
   end

   assign cmd_rdata = cmd_q;

   // registered action outputs
   logic                 buf_we_q;
   logic [WORD_BITS-1:0] buf_word_q;
   logic [DATA_W-1:0]    buf_wdata_q;
   logic                 lock_wr_q;
   logic [FUSE_W-1:0]    lock_wdata_q;
   logic                 rww_en_q;
   logic                 sig_rd_q;
   logic [FUSE_W-1:0]    sig_rdata_q;
   logic                 op_is_write_q;
   logic [PAGE_BITS-1:0] op_page_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_we_q      <= 1'b0;
         buf_word_q    <= '0;
         buf_wdata_q   <= '0;
         lock_wr_q     <= 1'b0;
         lock_wdata_q  <= '0;
         rww_en_q      <= 1'b0;
         sig_rd_q      <= 1'b0;
         sig_rdata_q   <= '0;
         op_is_write_q <= 1'b0;
         op_page_q     <= '0;
      end else begin
         buf_we_q  <= fire && (cur_kind == K_FILL);
         lock_wr_q <= fire && (cur_kind == K_LOCK);
         rww_en_q  <= fire && (cur_kind == K_RWW);
         sig_rd_q  <= load_fire;
         if (fire && (cur_kind == K_FILL)) begin
            buf_word_q  <= word_idx;
            buf_wdata_q <= data_in;
         end
         if (fire && (cur_kind == K_LOCK)) begin
            lock_wdata_q <= data_in[FUSE_W-1:0];
         end
         if (load_fire) begin
            sig_rdata_q <= sel_bit ? fuse_val : lock_val;
         end
         if (long_op) begin
            op_is_write_q <= (cur_kind == K_WRITE);
            op_page_q     <= page_idx;
         end
      end
   end

   assign buf_we      = buf_we_q;
   assign buf_word    = buf_word_q;
   assign buf_wdata   = buf_wdata_q;
   assign lock_wr     = lock_wr_q;
   assign lock_wdata  = lock_wdata_q;
   assign rww_en      = rww_en_q;
   assign sig_rd      = sig_rd_q;
   assign sig_rdata   = sig_rdata_q;
   assign op_is_write = op_is_write_q;
   assign op_page     = op_page_q;

endmodule

// File: rtl/spm_arm_ctrl_chk.sv
module spm_arm_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [4:0] cmd_rdata,
   input logic       buf_we,
   input logic       op_start,
   input logic       lock_wr,
   input logic       rww_en,
   input logic       sig_rd,
   input logic       cpu_halt,
   input logic       op_active,
   input logic       armed
);

   // R2: the register only ever holds idle or an accepted code
   a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rdata == 5'b00000) || (cmd_rdata == 5'b00001) || (cmd_rdata == 5'b00011) ||
      (cmd_rdata == 5'b00101) || (cmd_rdata == 5'b01001) || (cmd_rdata == 5'b10001));

   // R3: a non-idle code outside a long operation implies a running window
   a_r3_code_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_rdata != 5'b00000) && !op_active) |-> armed);

   // R4: buffer write is a single-cycle pulse
   a_r4_fill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |=> !buf_we);

   // R5: start is a single-cycle pulse
   a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |=> !op_start);

   // R6: enable and exactly one of erase/write held during the operation
   a_r6_enable_held: assert property (@(posedge clk) disable iff (!rst_n)
      op_active |-> (cmd_rdata[0] && (cmd_rdata[1] ^ cmd_rdata[2])));

   // R7: halt only inside a long operation
   a_r7_halt_in_op: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_halt |-> op_active);

   // R8: a special read result only follows the lock command
   a_r8_sig_under_lock: assert property (@(posedge clk) disable iff (!rst_n)
      sig_rd |-> (cmd_rdata == 5'b01001));

   // R9: at most one store action per cycle
   a_r9_one_action: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({buf_we, op_start, lock_wr, rww_en}));

endmodule

bind spm_arm_ctrl spm_arm_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_rdata (cmd_rdata),
   .buf_we    (buf_we),
   .op_start  (op_start),
   .lock_wr   (lock_wr),
   .rww_en    (rww_en),
   .sig_rd    (sig_rd),
   .cpu_halt  (cpu_halt),
   .op_active (op_active),
   .armed     (armed)
);

// File: tb/spm_arm_ctrl_bench.sv
`timescale 1ns/1ps
module spm_arm_ctrl_bench;

   localparam int LAT = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [4:0]  cmd_wdata = '0;
   logic [4:0]  cmd_rdata;
   logic [23:0] ptr = '0;
   logic [15:0] data_in = '0;
   logic        st_strobe = 1'b0;
   logic        ld_strobe = 1'b0;
   logic [7:0]  lock_val = 8'hA5;
   logic [7:0]  fuse_val = 8'h3C;
   logic        buf_we;
   logic [6:0]  buf_word;
   logic [15:0] buf_wdata;
   logic        lock_wr;
   logic [7:0]  lock_wdata;
   logic        rww_en;
   logic        sig_rd;
   logic [7:0]  sig_rdata;
   logic        op_start;
   logic        op_is_write;
   logic [8:0]  op_page;
   logic        op_busy = 1'b0;
   logic        cpu_halt;

   int vectors = 0;
   int miscompares = 0;
   int lat_cnt = 0;
   bit done_flag = 1'b0;

   always #4 clk = ~clk;

   spm_arm_ctrl u_spm_arm_ctrl (
      .clk (clk), .rst_n (rst_n), .cmd_wr (cmd_wr), .cmd_wdata (cmd_wdata),
      .cmd_rdata (cmd_rdata), .ptr (ptr), .data_in (data_in),
      .st_strobe (st_strobe), .ld_strobe (ld_strobe),
      .lock_val (lock_val), .fuse_val (fuse_val),
      .buf_we (buf_we), .buf_word (buf_word), .buf_wdata (buf_wdata),
      .lock_wr (lock_wr), .lock_wdata (lock_wdata), .rww_en (rww_en),
      .sig_rd (sig_rd), .sig_rdata (sig_rdata),
      .op_start (op_start), .op_is_write (op_is_write), .op_page (op_page),
      .op_busy (op_busy), .cpu_halt (cpu_halt)
   );

   // flash array model: busy for LAT cycles after a start pulse
   always @(negedge clk) begin
      if (op_start) begin
         op_busy = 1'b1;
         lat_cnt = LAT;
      end else if (lat_cnt > 1) begin
         lat_cnt = lat_cnt - 1;
      end else if (lat_cnt == 1) begin
         lat_cnt = 0;
         op_busy = 1'b0;
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr_cmd(input logic [4:0] v);
      cmd_wr = 1'b1;
      cmd_wdata = v;
      step();
      cmd_wr = 1'b0;
   endtask

   task automatic store();
      st_strobe = 1'b1;
      step();
      st_strobe = 1'b0;
   endtask

   task automatic load();
      ld_strobe = 1'b1;
      step();
      ld_strobe = 1'b0;
   endtask

   function automatic logic [23:0] mkptr(input int page, input int word, input bit lsb);
      return {7'd0, 9'(page), 7'(word), lsb};
   endfunction

   task automatic t_reset();
      chk("R1 cmd", 32'(cmd_rdata), 0);
      chk("R1 actions", 32'({buf_we, op_start, lock_wr, rww_en, sig_rd, cpu_halt}), 0);
   endtask

   task automatic t_fill();
      wr_cmd(5'b00001);
      chk("R2 accept fill", 32'(cmd_rdata), 32'h01);
      ptr = mkptr(5, 7'h2A, 1'b1);
      data_in = 16'hBEEF;
      store();
      chk("R4 buf_we", 32'(buf_we), 1);
      chk("R4 word (lsb ignored)", 32'(buf_word), 32'h2A);
      chk("R4 data", 32'(buf_wdata), 32'hBEEF);
      chk("R4 cleared", 32'(cmd_rdata), 0);
      step();
      chk("R4 single pulse", 32'(buf_we), 0);
   endtask

   task automatic t_illegal();
      wr_cmd(5'b00111);
      chk("R2 reject 00111", 32'(cmd_rdata), 0);
      wr_cmd(5'b11001);
      chk("R2 reject 11001", 32'(cmd_rdata), 0);
      wr_cmd(5'b00001);
      wr_cmd(5'b00110);
      chk("R2 armed kept", 32'(cmd_rdata), 32'h01);
      ptr = mkptr(1, 3, 1'b0);
      store();
      chk("R2 armed still fires", 32'(buf_we), 1);
      store();
      chk("R3 idle strobe ignored", 32'(buf_we), 0);
   endtask

   task automatic t_window();
      wr_cmd(5'b00001);
      for (int i = 0; i < 3; i++) step();
      ptr = mkptr(2, 9, 1'b0);
      data_in = 16'h1111;
      store();
      chk("R3 fourth cycle fires", 32'(buf_we), 1);
      wr_cmd(5'b00001);
      for (int i = 0; i < 4; i++) step();
      chk("R3 expired", 32'(cmd_rdata), 0);
      store();
      chk("R3 late strobe ignored", 32'(buf_we), 0);
   endtask

   task automatic t_rearm();
      wr_cmd(5'b00001);
      step();
      step();
      wr_cmd(5'b01001);
      for (int i = 0; i < 3; i++) step();
      chk("R10 restarted window", 32'(cmd_rdata), 32'h09);
      data_in = 16'h775A;
      store();
      chk("R9 lock_wr", 32'(lock_wr), 1);
      chk("R9 lock data", 32'(lock_wdata), 32'h5A);
      chk("R9 lock cleared", 32'(cmd_rdata), 0);
      chk("R10 no fill", 32'(buf_we), 0);
   endtask

   task automatic t_sig_read();
      wr_cmd(5'b01001);
      ptr = mkptr(0, 0, 1'b1);
      load();
      chk("R8 fuse rd", 32'(sig_rd), 1);
      chk("R8 fuse data", 32'(sig_rdata), 32'h3C);
      wr_cmd(5'b01001);
      ptr = mkptr(0, 0, 1'b0);
      step();
      step();
      load();
      chk("R8 third-cycle lock rd", 32'(sig_rd), 1);
      chk("R8 lock data", 32'(sig_rdata), 32'hA5);
      wr_cmd(5'b01001);
      for (int i = 0; i < 3; i++) step();
      load();
      chk("R8 fourth-cycle ignored", 32'(sig_rd), 0);
      step();
   endtask

   task automatic t_rww();
      wr_cmd(5'b10001);
      store();
      chk("R9 rww_en", 32'(rww_en), 1);
      chk("R9 rww cleared", 32'(cmd_rdata), 0);
   endtask

   task automatic t_long(input bit is_wr, input int page, input bit exp_halt);
      logic [4:0] code;
      code = is_wr ? 5'b00101 : 5'b00011;
      wr_cmd(code);
      ptr = mkptr(page, 3, 1'b0);
      data_in = 16'h1234;
      store();
      chk("R5 op_start", 32'(op_start), 1);
      chk("R5 op_is_write", 32'(op_is_write), 32'(is_wr));
      chk("R5 op_page", 32'(op_page), 32'(page));
      chk("R5 data ignored", 32'(buf_we), 0);
      chk("R7 halt", 32'(cpu_halt), 32'(exp_halt));
      wr_cmd(5'b00001);
      chk("R6 write ignored", 32'(cmd_rdata), 32'(code));
      for (int i = 0; i < 50 && op_busy; i++) begin
         chk("R6 held", 32'(cmd_rdata), 32'(code));
         chk("R7 halt held", 32'(cpu_halt), 32'(exp_halt));
         step();
      end
      chk("R6 held at busy fall", 32'(cmd_rdata), 32'(code));
      step();
      chk("R6 cleared after op", 32'(cmd_rdata), 0);
      chk("R7 halt released", 32'(cpu_halt), 0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_fill();
      t_illegal();
      t_window();
      t_rearm();
      t_sig_read();
      t_rww();
      t_long(1'b0, 500, 1'b1);
      t_long(1'b1, 10, 1'b0);
      done_flag = 1'b1;
      summary();
   end

endmodule